// File: doc/BRIEF.md
# DPLL Holdover Control Word Generator

This block sits between a digital PLL loop filter and the oscillator it steers. While the loop is locked, it passes the live frequency control word straight to the oscillator after one register stage. On each sample strobe it records the word in a history and folds it into a running average. The strobe is chosen so that a fixed number of strobes spans the look-back time the system wants.

When a holdover request arrives, the output freezes on a held word. A policy read at the moment of entry decides where that word comes from. It can be a delayed sample from the history, the running average, or a forced mid-scale word. The history and the average stop updating for the whole holdover. When the request drops, the output follows the live word again on the next clock edge.

The policy comes from a two-bit mode input and an averaging-enable input. Code 00 selects the delayed sample, 01 the average and 11 the mid-scale word. Code 10 is reserved and behaves like 00. When averaging is disabled, the mode is ignored and the delayed sample is used.

Top module: `hov_cw_gen`

## Requirements
- R1: While reset is asserted, `ctl_cw` is 0. Reset also clears every history slot and the average to 0.
- R2: In any cycle where `hold_req` is low and the previous cycle was not a holdover, the next edge loads `ctl_cw` with that cycle's `live_cw`.
- R3: A cycle with `smp_stb` high and `hold_req` low records `live_cw`. The delayed sample is the oldest of the last `HIST_DEPTH` recorded words, counting 0 for slots never written. With `avg_en` high and `hold_mode` = 2'b00, the edge that starts a holdover loads `ctl_cw` with this delayed sample.
- R4: The same strobe updates the average A to A + floor((live_cw − A) / 2^`AVG_SHIFT`). With `avg_en` high and `hold_mode` = 2'b01, holdover entry loads A.
- R5: With `avg_en` high and `hold_mode` = 2'b11, holdover entry loads 2^(`CW_W`−1).
- R6: With `avg_en` high and `hold_mode` = 2'b10 (reserved), holdover entry loads the delayed sample of R3.
- R7: With `avg_en` low, holdover entry loads the delayed sample whatever `hold_mode` holds.
- R8: While `hold_req` stays high after entry, `ctl_cw` does not change. During this time `live_cw`, `smp_stb`, `hold_mode` and `avg_en` have no effect, and neither the history nor the average updates.
- R9: In the first cycle with `hold_req` low after a holdover, the next edge loads `ctl_cw` with that cycle's `live_cw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| live_cw | input | CW_W | Live control word from the loop filter |
| smp_stb | input | 1 | Sample strobe for history and average |
| hold_req | input | 1 | Holdover request, level |
| hold_mode | input | 2 | Holdover policy code |
| avg_en | input | 1 | Averaging enable; low forces the delayed-sample policy |
| ctl_cw | output | CW_W | Control word to the oscillator |

## Verification
The assertions assume `hold_req` is low across reset and for the first cycles after release. They also assume `live_cw` stays 0 until the internal reset synchronizer has released. The bench keeps these assumptions by holding every input at 0 during reset and for four idle cycles afterwards. After that it drives random live words and strobes, with holdover episodes of random length from one cycle upward. The entry policy rotates over every mode code, with and without averaging. The first episode starts before the history is full, so the zero-filled slots are exercised.

// File: rtl/hov_pkg.sv
`timescale 1ns/1ps
package hov_pkg;

  typedef enum logic [1:0] {
    POL_DELAY = 2'd0,
    POL_AVG   = 2'd1,
    POL_MID   = 2'd2
  } hov_pol_e;

  // Decode the held-word policy from the mode code and averaging enable.
  function automatic hov_pol_e hov_pick(input logic en, input logic [1:0] mode);
    hov_pol_e pol;
    pol = POL_DELAY;
    if (en) begin
      unique case (mode)
        2'b01:   pol = POL_AVG;
        2'b11:   pol = POL_MID;
        default: pol = POL_DELAY;  // 00 and reserved 10
      endcase
    end
    return pol;
  endfunction

endpackage

// File: rtl/hov_rst_sync.sv
`timescale 1ns/1ps
module hov_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hov_hist.sv
`timescale 1ns/1ps
module hov_hist #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] oldest
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0]           ptr_q;
  logic [PW-1:0]           ptr_d;
  logic [DEPTH-1:0][W-1:0] rd_vec;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_we;
    assign slot_we = wr_en && (ptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= din;
    end
    assign rd_vec[i] = slot_q;
  end

  // The slot about to be overwritten holds the oldest recorded word.
  assign oldest = rd_vec[ptr_q];
endmodule

// File: rtl/hov_iir.sv
`timescale 1ns/1ps
module hov_iir #(
  parameter int W     = 16,
  parameter int SHIFT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] avg
);
  // One guard bit keeps the difference and the sum signed without overflow.
  logic signed [W:0] acc_q;
  logic signed [W:0] acc_d;
  logic signed [W:0] diff;
  logic signed [W:0] step;

  always_comb begin
    diff  = $signed({1'b0, din}) - acc_q;
    step  = diff >>> SHIFT;
    acc_d = acc_q;
    if (upd) acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign avg = acc_q[W-1:0];
endmodule

// File: rtl/hov_cw_gen.sv
`timescale 1ns/1ps
module hov_cw_gen
  import hov_pkg::*;
#(
  parameter int CW_W       = 16,
  parameter int HIST_DEPTH = 8,
  parameter int AVG_SHIFT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] live_cw,
  input  logic            smp_stb,
  input  logic            hold_req,
  input  logic [1:0]      hold_mode,
  input  logic            avg_en,
  output logic [CW_W-1:0] ctl_cw
);
  localparam logic [CW_W-1:0] MID_CW = {1'b1, {(CW_W-1){1'b0}}};

  logic            rst_sync_n;
  logic            upd;
  logic            entry;
  logic [CW_W-1:0] dly_cw;
  logic [CW_W-1:0] avg_cw;
  logic [CW_W-1:0] held_cw;
  hov_pol_e        pol;

  logic            hold_q, hold_d;
  logic [CW_W-1:0] ctl_q, ctl_d;

  hov_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign upd = smp_stb & ~hold_req;

  hov_hist #(.W(CW_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (upd),
    .din    (live_cw),
    .oldest (dly_cw)
  );

  hov_iir #(.W(CW_W), .SHIFT(AVG_SHIFT)) u_iir (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .upd   (upd),
    .din   (live_cw),
    .avg   (avg_cw)
  );

  always_comb begin
    pol   = hov_pick(avg_en, hold_mode);
    entry = hold_req & ~hold_q;
    unique case (pol)
      POL_AVG: held_cw = avg_cw;
      POL_MID: held_cw = MID_CW;
      default: held_cw = dly_cw;
    endcase
    hold_d = hold_req;
    if (!hold_req)  ctl_d = live_cw;
    else if (entry) ctl_d = held_cw;
    else            ctl_d = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q <= 1'b0;
      ctl_q  <= '0;
    end else begin
      hold_q <= hold_d;
      ctl_q  <= ctl_d;
    end
  end

  assign ctl_cw = ctl_q;
endmodule

// File: rtl/hov_cw_gen_chk.sv
`timescale 1ns/1ps
module hov_cw_gen_chk #(
  parameter int CW_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW_W-1:0] live_cw,
  input logic            hold_req,
  input logic [1:0]      hold_mode,
  input logic            avg_en,
  input logic [CW_W-1:0] ctl_cw
);
  localparam logic [CW_W-1:0] MID_CW = {1'b1, {(CW_W-1){1'b0}}};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (ctl_cw == '0);
    end
  end

  // R9
  follow_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |=> ctl_cw == $past(live_cw));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && $past(hold_req)) |=> $stable(ctl_cw));

  // R5
  mid_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hold_req) && avg_en && hold_mode == 2'b11) |=> ctl_cw == MID_CW);
endmodule

bind hov_cw_gen hov_cw_gen_chk #(.CW_W(CW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .live_cw   (live_cw),
  .hold_req  (hold_req),
  .hold_mode (hold_mode),
  .avg_en    (avg_en),
  .ctl_cw    (ctl_cw)
);

// File: tb/hov_cw_gen_tb_top.sv
`timescale 1ns/1ps
module hov_cw_gen_tb_top;
  localparam int W  = 16;
  localparam int D  = 8;
  localparam int SH = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] live_cw;
  logic         smp_stb;
  logic         hold_req;
  logic [1:0]   hold_mode;
  logic         avg_en;
  logic [W-1:0] ctl_cw;

  always #2.5 clk = ~clk;

  hov_cw_gen #(.CW_W(W), .HIST_DEPTH(D), .AVG_SHIFT(SH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_cw   (live_cw),
    .smp_stb   (smp_stb),
    .hold_req  (hold_req),
    .hold_mode (hold_mode),
    .avg_en    (avg_en),
    .ctl_cw    (ctl_cw)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  int    hist_m[$];
  int    avg_m;
  int    out_m;
  bit    hq_m;
  string tag_m;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: ctl_cw actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    hist_m.delete();
    for (int i = 0; i < D; i++) hist_m.push_back(0);
    avg_m = 0;
    out_m = 0;
    hq_m  = 1'b0;
    tag_m = "R1";
  endfunction

  // Behavioural reference: queue of recorded words, integer average.
  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else if (hold_req) begin
      if (!hq_m) begin
        if (!avg_en) begin
          out_m = hist_m[0];
          tag_m = (hold_mode != 2'b00) ? "R7" : "R3";
        end else begin
          case (hold_mode)
            2'b01:   begin out_m = avg_m;        tag_m = "R4"; end
            2'b11:   begin out_m = 1 << (W - 1); tag_m = "R5"; end
            2'b10:   begin out_m = hist_m[0];    tag_m = "R6"; end
            default: begin out_m = hist_m[0];    tag_m = "R3"; end
          endcase
        end
      end else begin
        tag_m = "R8";
      end
      hq_m = 1'b1;
    end else begin
      out_m = int'(live_cw);
      tag_m = hq_m ? "R9" : "R2";
      hq_m  = 1'b0;
      if (smp_stb) begin
        hist_m.push_back(int'(live_cw));
        void'(hist_m.pop_front());
        avg_m = avg_m + ((int'(live_cw) - avg_m) >>> SH);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    check(tag_m, int'(ctl_cw), out_m);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    model_reset();
    rst_n     = 1'b0;
    live_cw   = '0;
    smp_stb   = 1'b0;
    hold_req  = 1'b0;
    hold_mode = 2'b00;
    avg_en    = 1'b0;
    // R1: output held at zero during reset
    repeat (3) begin
      @(negedge clk);
      check("R1", int'(ctl_cw), 0);
    end
    rst_n = 1'b1;
    repeat (4) tick();
    for (int ep = 0; ep < 300; ep++) begin
      int lock_len;
      int hold_len;
      lock_len = (ep == 0) ? 3 : 4 + $urandom_range(0, 40);
      for (int c = 0; c < lock_len; c++) begin
        tick();
        hold_req  = 1'b0;
        live_cw   = W'($urandom);
        smp_stb   = ($urandom_range(0, 2) != 0);
        hold_mode = 2'($urandom_range(0, 3));
        avg_en    = 1'($urandom_range(0, 1));
      end
      hold_len = 1 + $urandom_range(0, 8);
      for (int c = 0; c < hold_len; c++) begin
        tick();
        hold_req = 1'b1;
        live_cw  = W'($urandom);
        smp_stb  = 1'($urandom_range(0, 1));
        if (c == 0) begin
          avg_en    = (ep % 5 != 4);
          hold_mode = 2'(ep % 4);
        end else begin
          hold_mode = 2'($urandom_range(0, 3));
          avg_en    = 1'($urandom_range(0, 1));
        end
      end
    end
    tick();
    hold_req = 1'b0;
    repeat (3) tick();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2: watchdog actual run still busy, expected completion");
      summary();
      $finish;
    end
  end
endmodule